// File: doc/BRIEF.md
# Memory-to-memory serial RISC core

This block is a small 16-bit processor without a register file. Each instruction names three operands: two sources, A and B, and a destination, C. Every operand is either a literal value or a word held in data RAM. Instructions are read from a separate read-only program store that sits outside the core and answers combinationally. The program counter is not a dedicated register. It is the RAM word at address 0, so any instruction that writes that word redirects execution. Branches are built from two conditional moves: one writes when its A value is negative, the other writes when its A value is nonzero.

Each instruction runs through five fixed steps: fetch, resolve A, resolve B, resolve the destination address, and execute with writeback. The commit strobe marks the execute step. In that same cycle the port `wr_en` shows whether a write happens, and if so its address and data. A halt output is raised when an instruction jumps to its own address. The core then stops issuing instructions.

Top module: `memcore_top`

## Requirements
- R1: While `rst` is high, every RAM word is cleared to 0, so the PC restarts at 0. After `rst` falls, `halt`, `commit` and `wr_en` are low, and reading any RAM address before it is written returns 0.
- R2: Each instruction takes exactly five clock cycles, starting with the first rising edge after reset. `commit` is high only in the fifth cycle. `wr_en` is never high outside a commit cycle. The `pc` output changes only on the edge that ends a commit cycle.
- R3: The instruction word is laid out as opcode[57:54], A mode[53:52], A value[51:36], B mode[35:34], B value[33:18], C mode[17:16] and C value[15:0].
  - Mode 1 means direct: the operand is RAM[value].
  - Mode 2 means indirect: the operand is RAM[RAM[value]].
  - Modes 0 and 3 mean the operand is the value itself.
  - The destination address is found the same way.
  - All RAM addresses are taken modulo the RAM depth.
- R4: Opcode 2 writes A+B and opcode 3 writes A-B, both modulo 2^16.
- R5: Opcode 1 writes B to C only when bit 15 of A is set. Otherwise it writes nothing.
- R6: Opcode 0 writes B to C only when A is nonzero. Otherwise it writes nothing.
- R7: Opcode 4 writes A shifted left by B, and opcode 5 writes A shifted right logically by B. If B (unsigned) is greater than 15, both write 0.
- R8: Opcode 6 writes A shifted right arithmetically by B. If B is greater than 15, every result bit equals bit 15 of A.
- R9: Opcodes 7 to 15 write nothing. They only advance the PC.
- R10: Reading address 0 yields the address of the current instruction. After a commit that does not write address 0, the PC becomes its old value plus 1. After a commit that does write address 0, the PC becomes the written value. The program store is addressed by the low bits of the PC.
- R11: When a commit writes address 0 with a value equal to the current PC, `halt` goes high on the next cycle and stays high until reset. No further commits or writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_addr | output | PROG_AW | Program store address (low bits of the PC) |
| prog_word | input | 58 | Instruction word at `prog_addr` |
| pc | output | 16 | Current PC, i.e. RAM word 0 |
| commit | output | 1 | High in the execute cycle of each instruction |
| wr_en | output | 1 | A RAM write happens in this commit cycle |
| wr_addr | output | log2(RAM_DEPTH) | Write address |
| wr_data | output | 16 | Write data |
| halt | output | 1 | Core has stopped on a jump to itself |

## Verification
The bench builds the core with its default values: a RAM depth of 32 and 8 program address bits. The small RAM depth makes address aliasing reachable. A destination address of 32 folds onto the PC word and acts as a jump. The 8-bit program address lets each test program, with its jumps, its countdown loop and the unused entries after it, fit in one short table. A behavioural model steps through the same programs using plain integers. It is compared against the core on every clock for the PC, the commit timing, every write and the halt flag. The programs also cover shift amounts above 15, overflow in both directions, and conditional moves that do not fire.

// File: rtl/memcore_pkg.sv
package memcore_pkg;
  localparam int DW  = 16;
  localparam int OPW = 4;
  localparam int MDW = 2;
  localparam int IW  = OPW + 3 * (MDW + DW);

  localparam logic [OPW-1:0] OP_MNZ = 4'd0;
  localparam logic [OPW-1:0] OP_MLZ = 4'd1;
  localparam logic [OPW-1:0] OP_ADD = 4'd2;
  localparam logic [OPW-1:0] OP_SUB = 4'd3;
  localparam logic [OPW-1:0] OP_SL  = 4'd4;
  localparam logic [OPW-1:0] OP_SRL = 4'd5;
  localparam logic [OPW-1:0] OP_SRA = 4'd6;

  localparam logic [MDW-1:0] MD_DIRECT   = 2'd1;
  localparam logic [MDW-1:0] MD_INDIRECT = 2'd2;

  typedef struct packed {
    logic [MDW-1:0] mode;
    logic [DW-1:0]  val;
  } operand_t;

  typedef struct packed {
    logic [OPW-1:0] op;
    operand_t       a;
    operand_t       b;
    operand_t       c;
  } instr_t;

  typedef struct packed {
    logic          we;
    logic [DW-1:0] data;
  } alu_out_t;

  typedef enum logic [2:0] {
    ST_FETCH, ST_OPA, ST_OPB, ST_OPC, ST_EXEC, ST_HALT
  } state_e;

  function automatic logic [DW-1:0] shift_word(input logic [OPW-1:0] op,
                                               input logic [DW-1:0] a,
                                               input logic [DW-1:0] b);
    logic       too_far;
    logic [3:0] amt;
    logic [DW-1:0] r;
    too_far = |b[DW-1:4];
    amt     = b[3:0];
    if (op == OP_SRA) begin
      r = too_far ? {DW{a[DW-1]}} : DW'($signed(a) >>> amt);
    end else if (op == OP_SRL) begin
      r = too_far ? '0 : (a >> amt);
    end else begin
      r = too_far ? '0 : (a << amt);
    end
    return r;
  endfunction

  function automatic alu_out_t exec_word(input logic [OPW-1:0] op,
                                         input logic [DW-1:0] a,
                                         input logic [DW-1:0] b);
    alu_out_t o;
    o.we   = 1'b0;
    o.data = b;
    case (op)
      OP_MNZ: o.we = (a != '0);
      OP_MLZ: o.we = a[DW-1];
      OP_ADD: begin o.we = 1'b1; o.data = a + b; end
      OP_SUB: begin o.we = 1'b1; o.data = a - b; end
      OP_SL, OP_SRL, OP_SRA: begin o.we = 1'b1; o.data = shift_word(op, a, b); end
      default: o.we = 1'b0;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/memcore_ram.sv
module memcore_ram
  import memcore_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_direct,
  output logic [DW-1:0] rd_indirect,
  output logic [DW-1:0] pc_word,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          pc_step_en,
  input  logic [DW-1:0] pc_step_val
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (pc_step_en) mem[0] <= pc_step_val;
      if (wr_en) mem[wr_addr] <= wr_data;
    end
  end

  assign rd_direct   = mem[rd_addr];
  assign rd_indirect = mem[rd_direct[AW-1:0]];
  assign pc_word     = mem[0];
endmodule

// File: rtl/memcore_ctrl.sv
module memcore_ctrl
  import memcore_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   halt_req,
  output state_e state
);
  state_e nxt;

  always_comb begin
    case (state)
      ST_FETCH: nxt = ST_OPA;
      ST_OPA:   nxt = ST_OPB;
      ST_OPB:   nxt = ST_OPC;
      ST_OPC:   nxt = ST_EXEC;
      ST_EXEC:  nxt = halt_req ? ST_HALT : ST_FETCH;
      default:  nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nxt;
  end
endmodule

// File: rtl/memcore_alu.sv
module memcore_alu
  import memcore_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  output logic           we,
  output logic [DW-1:0]  result
);
  alu_out_t o;
  assign o      = exec_word(op, a, b);
  assign we     = o.we;
  assign result = o.data;
endmodule

// File: rtl/memcore_top.sv
module memcore_top
  import memcore_pkg::*;
#(
  parameter int RAM_DEPTH = 32,
  parameter int PROG_AW   = 8,
  localparam int AW       = $clog2(RAM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PROG_AW-1:0] prog_addr,
  input  logic [IW-1:0]      prog_word,
  output logic [DW-1:0]      pc,
  output logic               commit,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output logic [DW-1:0]      wr_data,
  output logic               halt
);
  state_e        state;
  instr_t        ir;
  operand_t      cur;
  logic [DW-1:0] a_q, b_q, resolved;
  logic [AW-1:0] c_q;
  logic [DW-1:0] rd_direct, rd_indirect, pc_word;
  logic          alu_we, jump, halt_req, exec_cycle;
  logic [DW-1:0] alu_data;

  memcore_ctrl u_ctrl (
    .clk(clk), .rst(rst), .halt_req(halt_req), .state(state)
  );

  always_comb begin
    case (state)
      ST_OPA:  cur = ir.a;
      ST_OPB:  cur = ir.b;
      default: cur = ir.c;
    endcase
  end

  memcore_ram #(.DEPTH(RAM_DEPTH), .AW(AW)) u_ram (
    .clk(clk), .rst(rst),
    .rd_addr(cur.val[AW-1:0]),
    .rd_direct(rd_direct), .rd_indirect(rd_indirect), .pc_word(pc_word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pc_step_en(exec_cycle && !jump), .pc_step_val(pc_word + 16'd1)
  );

  always_comb begin
    case (cur.mode)
      MD_DIRECT:   resolved = rd_direct;
      MD_INDIRECT: resolved = rd_indirect;
      default:     resolved = cur.val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir  <= '0;
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else begin
      case (state)
        ST_FETCH: ir  <= prog_word;
        ST_OPA:   a_q <= resolved;
        ST_OPB:   b_q <= resolved;
        ST_OPC:   c_q <= resolved[AW-1:0];
        default: ;
      endcase
    end
  end

  memcore_alu u_alu (
    .op(ir.op), .a(a_q), .b(b_q), .we(alu_we), .result(alu_data)
  );

  assign exec_cycle = (state == ST_EXEC);
  assign wr_en      = exec_cycle && alu_we;
  assign wr_addr    = c_q;
  assign wr_data    = alu_data;
  assign jump       = wr_en && (c_q == '0);
  assign halt_req   = jump && (alu_data == pc_word);
  assign commit     = exec_cycle;
  assign halt       = (state == ST_HALT);
  assign pc         = pc_word;
  assign prog_addr  = pc_word[PROG_AW-1:0];
endmodule

// File: rtl/memcore_chk.sv
module memcore_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [15:0]   pc,
  input logic          commit,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [15:0]   wr_data,
  input logic          halt
);
  logic [2:0] gap;

  always_ff @(posedge clk) begin
    if (rst)         gap <= '0;
    else if (commit) gap <= '0;
    else if (gap != 3'd7) gap <= gap + 3'd1;
  end

  p_commit_gap_r2: assert property (@(posedge clk) disable iff (rst)
    commit |-> gap == 3'd4);
  p_write_in_commit_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> commit);
  p_pc_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(commit)) |-> $stable(pc));
  p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
    (commit && !(wr_en && wr_addr == '0)) |=> pc == $past(pc) + 16'd1);
  p_pc_jump_r10: assert property (@(posedge clk) disable iff (rst)
    (commit && wr_en && wr_addr == '0) |=> pc == $past(wr_data));
  p_halt_entry_r11: assert property (@(posedge clk) disable iff (rst)
    (commit && wr_en && wr_addr == '0 && wr_data == pc) |=> halt);
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);
  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    halt |-> (!commit && !wr_en));
endmodule

bind memcore_top memcore_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .pc(pc), .commit(commit), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .halt(halt)
);

// File: tb/memcore_top_tb_top.sv
`timescale 1ns/1ps
module memcore_top_tb_top;
  localparam int DEPTH = 32;
  localparam int PAW   = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  prog_addr;
  logic [57:0] prog_word;
  logic [15:0] pc;
  logic        commit, wr_en, halt;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;

  logic [57:0] rom [256];
  int m [DEPTH];
  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  assign prog_word = rom[prog_addr];

  memcore_top #(.RAM_DEPTH(DEPTH), .PROG_AW(PAW)) dut_i (
    .clk(clk), .rst(rst), .prog_addr(prog_addr), .prog_word(prog_word),
    .pc(pc), .commit(commit), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .halt(halt)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [57:0] ins(int op, int ma, int va, int mb, int vb,
                                      int mc, int vc);
    logic [57:0] w;
    w = {op[3:0], ma[1:0], va[15:0], mb[1:0], vb[15:0], mc[1:0], vc[15:0]};
    return w;
  endfunction

  function automatic int opnd(int mode, int v);
    if (mode == 1) return m[v % DEPTH];
    if (mode == 2) return m[m[v % DEPTH] % DEPTH];
    return v & 16'hffff;
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0: return "R6";
      1: return "R5";
      2, 3: return "R4";
      4, 5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = '0;
  endtask

  task automatic run_prog();
    int n = 0;
    int after = 0;
    bit stopped = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) m[i] = 0;
    chk(pc == 0 && halt == 0 && commit == 0 && wr_en == 0, "R1",
        "reset state", {pc, halt, commit, wr_en}, 0);
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      n++;
      if (stopped) begin
        chk(halt == 1 && commit == 0 && wr_en == 0, "R11", "halted quiet",
            {halt, commit, wr_en}, 3'b100);
        chk(pc == m[0], "R11", "pc frozen", pc, m[0]);
        after++;
        if (after == 6) break;
      end else begin
        int exp_c;
        exp_c = (n % 5 == 4);
        chk(pc == m[0], "R10", "pc value", pc, m[0]);
        chk(commit == exp_c && halt == 0, "R2", "commit timing",
            {commit, halt}, exp_c * 2);
        if (exp_c != 0) begin
          logic [57:0] w;
          int op, a, b, da, res, sa, sh;
          bit we;
          w  = rom[m[0] % 256];
          op = int'(w[57:54]);
          a  = opnd(int'(w[53:52]), int'(w[51:36]));
          b  = opnd(int'(w[35:34]), int'(w[33:18]));
          da = opnd(int'(w[17:16]), int'(w[15:0])) % DEPTH;
          we = 1; res = b;
          case (op)
            0: we = (a != 0);
            1: we = (a >= 32768);
            2: res = (a + b) & 16'hffff;
            3: res = (a - b) & 16'hffff;
            4: res = (b > 15) ? 0 : ((a << b) & 16'hffff);
            5: res = (b > 15) ? 0 : (a >> b);
            6: begin
              sa = (a >= 32768) ? a - 65536 : a;
              sh = (b > 15) ? 15 : b;
              res = (sa >>> sh) & 16'hffff;
            end
            default: we = 0;
          endcase
          chk(wr_en == we, op_tag(op), "write enable", wr_en, we);
          if (we) begin
            chk(wr_addr == da && wr_data == res, op_tag(op), "R3 write addr/data",
                {wr_addr, wr_data}, (da << 16) | res);
          end
          if (we && da == 0) begin
            if (res == m[0]) stopped = 1;
            m[0] = res;
          end else begin
            if (we) m[da] = res;
            m[0] = (m[0] + 1) & 16'hffff;
          end
        end
      end
    end
    chk(stopped, "R11", "program reached halt", stopped, 1);
  endtask

  initial begin
    // Program 1: data operations, modes, conditional moves, jumps.
    clear_rom();
    rom[0]  = ins(1, 0, 16'hffff, 0, 16'h7fff, 0, 5);
    rom[1]  = ins(2, 1, 5, 0, 1, 0, 6);                 // R4 overflow
    rom[2]  = ins(3, 0, 0, 0, 1, 0, 7);                 // R4 underflow
    rom[3]  = ins(4, 0, 16'h00f1, 0, 3, 0, 8);          // R7
    rom[4]  = ins(4, 0, 1, 0, 16, 0, 9);                // R7 far
    rom[5]  = ins(5, 1, 6, 0, 15, 0, 10);               // R7
    rom[6]  = ins(6, 1, 6, 0, 4, 0, 11);                // R8
    rom[7]  = ins(6, 1, 6, 0, 16'h0020, 0, 12);         // R8 far
    rom[8]  = ins(5, 1, 7, 0, 0, 0, 13);
    rom[9]  = ins(1, 0, 5, 0, 16'h1234, 0, 14);         // R5 no write
    rom[10] = ins(1, 1, 7, 0, 16'h1234, 0, 14);         // R5 write
    rom[11] = ins(0, 0, 0, 0, 16'h55, 0, 15);           // R6 no write
    rom[12] = ins(0, 1, 14, 0, 16'h55, 0, 15);          // R6 write
    rom[13] = ins(1, 0, 16'hffff, 0, 8, 0, 16);
    rom[14] = ins(2, 2, 16, 0, 1, 1, 16);               // R3 indirect
    rom[15] = ins(9, 0, 1, 0, 2, 0, 3);                 // R9
    rom[16] = ins(1, 0, 16'hffff, 1, 0, 0, 17);         // R10 read pc
    rom[17] = ins(1, 0, 16'hffff, 0, 20, 0, 0);         // R10 jump
    rom[18] = ins(1, 0, 16'hffff, 0, 16'hdead, 0, 18);
    rom[19] = ins(1, 0, 16'hffff, 0, 16'hdead, 0, 19);
    rom[20] = ins(0, 0, 1, 0, 22, 0, 0);
    rom[21] = ins(1, 0, 16'hffff, 0, 16'hdead, 0, 21);
    rom[22] = ins(2, 1, 30, 0, 0, 0, 29);               // R1 unwritten
    rom[23] = ins(1, 0, 16'hffff, 0, 23, 0, 0);         // R11 halt
    run_prog();

    // Program 2: countdown loop; RAM cleared by reset.
    clear_rom();
    rom[0] = ins(1, 0, 16'hffff, 1, 5, 0, 2);           // R1 after rerun
    rom[1] = ins(1, 0, 16'hffff, 0, 5, 0, 1);
    rom[2] = ins(3, 1, 1, 0, 1, 0, 1);
    rom[3] = ins(0, 1, 1, 0, 2, 0, 0);
    rom[4] = ins(1, 0, 16'hffff, 0, 4, 0, 0);
    run_prog();

    // Program 3: address aliasing and mode 3.
    clear_rom();
    rom[0] = ins(1, 0, 16'hffff, 0, 2, 0, 32);          // R3 alias to pc
    rom[1] = ins(1, 0, 16'hffff, 0, 16'hdead, 0, 1);
    rom[2] = ins(2, 3, 7, 0, 1, 0, 3);                  // R3 mode 3
    rom[3] = ins(13, 1, 3, 1, 3, 0, 0);                 // R9 dest 0 ignored
    rom[4] = ins(1, 0, 16'hffff, 0, 4, 0, 0);
    run_prog();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1_000_000;
    total++;
    fails++;
    $display("FAIL R2 watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule